// File: doc/BRIEF.md
# Fixed-Priority Shared SRAM Port Arbiter

This block puts four independent requesters onto one single-ported SRAM. Two sit on the flash side. One writes incoming flash data into the read-buffer region. The other reads outgoing data from the write-buffer region. The other two sit on the system-bus side. One reads from the read-buffer region and the other writes into the write-buffer region. Each cycle the block picks at most one requester by fixed rank. It drives the SRAM chip select, write enable, address and write data from that grant alone. Read data comes back to the reader that issued the read.

The flash-side writer has no back-pressure. Its transfer is taken in the same cycle that its `valid` is high, because the flash stream cannot pause. Each of the other three requesters uses a valid/ready handshake. The requester raises `valid` and holds its address and data stable until it sees `ready`. `ready` is high only in the cycle the access is made. Both sides may stay stalled for any number of cycles. Read data returns one cycle after the grant and is marked by a one-cycle `rvalid` strobe. The two system-bus sources share the lowest rank and should never be presented together. If they are, `bus_conflict` is raised and the write is served first.

Top module: `sram_port_arbiter`

## Requirements
- R1: At most one requester receives an access in any cycle, so at most one of `fr_ready`, `sr_ready` and `sw_ready` is high, and none of them is high while `fw_valid` is high.
- R2: Whenever `fw_valid` is high, the SRAM is written in that same cycle with `mem_cs`=1, `mem_we`=1, `mem_addr`=`fw_addr` and `mem_wdata`=`fw_data`, whatever the other requests are.
- R3: When `fw_valid` is low and `fr_valid` is high, `fr_ready` is high and the SRAM is read at `fr_addr` (`mem_we`=0).
- R4: `sr_ready` or `sw_ready` is high only in a cycle in which both flash-side requests are low.
- R5: One cycle after a read grant, only the granting reader's `rvalid` is high, for one cycle, and its `rdata` equals the word stored at the granted address.
- R6: If `sr_valid` and `sw_valid` are both high, `bus_conflict` is high in that cycle. If neither flash request is present, `sw_ready` is high and `sr_ready` is low.
- R7: In a cycle with no request, `mem_cs` is 0 and no SRAM access is made.
- R8: A system-bus write grant drives `mem_we`=1, `mem_addr`=`sw_addr` and `mem_wdata`=`sw_data`. A read grant drives `mem_we`=0.
- R9: After reset, with no requests, `fr_rvalid` and `sr_rvalid` are 0 and no ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fw_valid | input | 1 | Flash-side write into the read buffer; taken in the same cycle |
| fw_addr | input | ADDR_W | Address for the flash-side write |
| fw_data | input | DATA_W | Data for the flash-side write |
| fr_valid | input | 1 | Flash-side read request from the write buffer |
| fr_ready | output | 1 | Flash-side read accepted this cycle |
| fr_addr | input | ADDR_W | Address for the flash-side read |
| fr_rvalid | output | 1 | Flash-side read data valid |
| fr_rdata | output | DATA_W | Flash-side read data |
| sr_valid | input | 1 | System-bus read request from the read buffer |
| sr_ready | output | 1 | System-bus read accepted this cycle |
| sr_addr | input | ADDR_W | Address for the system-bus read |
| sr_rvalid | output | 1 | System-bus read data valid |
| sr_rdata | output | DATA_W | System-bus read data |
| sw_valid | input | 1 | System-bus write request into the write buffer |
| sw_ready | output | 1 | System-bus write accepted this cycle |
| sw_addr | input | ADDR_W | Address for the system-bus write |
| sw_data | input | DATA_W | Data for the system-bus write |
| bus_conflict | output | 1 | Both system-bus requests are present at once |
| mem_cs | output | 1 | SRAM chip select |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after a read select |

## Verification
Two functions can fall in the same cycle. The first is the return of read data for an earlier grant. The second is a new grant to a different requester that is stalled behind it. The bench provokes this by presenting the flash writer, the flash reader and the system-bus reader together, then removing each requester as it is served. In the cycle where the system-bus read is granted, the bench checks that `fr_rvalid` carries the word it expects for the earlier flash read, and that `sr_ready` is high in the same cycle. A system-bus write and a system-bus read presented together are judged on `bus_conflict`, on which ready is high, and on the value read back afterwards.

// File: rtl/srarb_pkg.sv
package srarb_pkg;
  localparam int NSRC  = 4;
  // rank order: lower index wins
  localparam int IX_FW = 0;
  localparam int IX_FR = 1;
  localparam int IX_SW = 2;
  localparam int IX_SR = 3;
  // sources that write the SRAM
  localparam logic [NSRC-1:0] WR_MASK = 4'b0101;
endpackage

// File: rtl/srarb_prio.sv
module srarb_prio
  import srarb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] gnt
);
  logic [NSRC:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_rank
    assign gnt[i]     = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R1
  AST_FW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req[IX_FW] |-> gnt[IX_FW]); // R2
endmodule

// File: rtl/srarb_mux.sv
module srarb_mux
  import srarb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSRC-1:0]             gnt,
  input  logic [NSRC-1:0][ADDR_W-1:0] addr_in,
  input  logic [NSRC-1:0][DATA_W-1:0] data_in,
  output logic                        cs,
  output logic                        we,
  output logic [ADDR_W-1:0]           addr,
  output logic [DATA_W-1:0]           wdata
);
  always_comb begin
    addr  = '0;
    wdata = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (gnt[i]) begin
        addr  = addr | addr_in[i];
        wdata = wdata | (data_in[i] & {DATA_W{WR_MASK[i]}});
      end
    end
  end

  assign cs = |gnt;
  assign we = |(gnt & WR_MASK);

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> cs); // R8
endmodule

// File: rtl/srarb_rdret.sv
module srarb_rdret #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_gnt,
  input  logic              sr_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fr_rvalid,
  output logic [DATA_W-1:0] fr_rdata,
  output logic              sr_rvalid,
  output logic [DATA_W-1:0] sr_rdata
);
  logic fr_q, sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= 1'b0;
      sr_q <= 1'b0;
    end else begin
      fr_q <= fr_gnt;
      sr_q <= sr_gnt;
    end
  end

  assign fr_rvalid = fr_q;
  assign sr_rvalid = sr_q;
  assign fr_rdata  = fr_q ? mem_rdata : '0;
  assign sr_rdata  = sr_q ? mem_rdata : '0;

  AST_FR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    fr_gnt |=> fr_rvalid && !sr_rvalid); // R5
  AST_SR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    sr_gnt |=> sr_rvalid && !fr_rvalid); // R5
endmodule

// File: rtl/sram_port_arbiter.sv
module sram_port_arbiter
  import srarb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_valid,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic [DATA_W-1:0] fw_data,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [ADDR_W-1:0] fr_addr,
  output logic              fr_rvalid,
  output logic [DATA_W-1:0] fr_rdata,
  input  logic              sr_valid,
  output logic              sr_ready,
  input  logic [ADDR_W-1:0] sr_addr,
  output logic              sr_rvalid,
  output logic [DATA_W-1:0] sr_rdata,
  input  logic              sw_valid,
  output logic              sw_ready,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_data,
  output logic              bus_conflict,
  output logic              mem_cs,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [NSRC-1:0]             req, gnt;
  logic [NSRC-1:0][ADDR_W-1:0] addr_v;
  logic [NSRC-1:0][DATA_W-1:0] data_v;

  always_comb begin
    req           = '0;
    req[IX_FW]    = fw_valid;
    req[IX_FR]    = fr_valid;
    req[IX_SW]    = sw_valid;
    req[IX_SR]    = sr_valid;
    addr_v        = '0;
    addr_v[IX_FW] = fw_addr;
    addr_v[IX_FR] = fr_addr;
    addr_v[IX_SW] = sw_addr;
    addr_v[IX_SR] = sr_addr;
    data_v        = '0;
    data_v[IX_FW] = fw_data;
    data_v[IX_SW] = sw_data;
  end

  srarb_prio u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt)
  );

  srarb_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .gnt     (gnt),
    .addr_in (addr_v),
    .data_in (data_v),
    .cs      (mem_cs),
    .we      (mem_we),
    .addr    (mem_addr),
    .wdata   (mem_wdata)
  );

  srarb_rdret #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .fr_gnt    (gnt[IX_FR]),
    .sr_gnt    (gnt[IX_SR]),
    .mem_rdata (mem_rdata),
    .fr_rvalid (fr_rvalid),
    .fr_rdata  (fr_rdata),
    .sr_rvalid (sr_rvalid),
    .sr_rdata  (sr_rdata)
  );

  assign fr_ready     = gnt[IX_FR];
  assign sr_ready     = gnt[IX_SR];
  assign sw_ready     = gnt[IX_SW];
  assign bus_conflict = sr_valid & sw_valid;

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fr_ready, sr_ready, sw_ready}) <= 1); // R1
  AST_FW_NO_PEER: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> !fr_ready && !sr_ready && !sw_ready); // R1
  AST_FW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> mem_cs && mem_we && mem_addr == fw_addr && mem_wdata == fw_data); // R2
  AST_FR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fw_valid) |-> fr_ready && !mem_we && mem_addr == fr_addr); // R3
  AST_SYS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_ready || sw_ready) |-> !fw_valid && !fr_valid); // R4
  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_valid && sw_valid && !fw_valid && !fr_valid) |-> sw_ready && !sr_ready); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(fw_valid || fr_valid || sr_valid || sw_valid) |-> !mem_cs); // R7
  AST_SW_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ready |-> mem_we && mem_addr == sw_addr && mem_wdata == sw_data); // R8
endmodule

// File: tb/test_sram_port_arbiter.sv
module test_sram_port_arbiter;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fw_valid = 0, fr_valid = 0, sr_valid = 0, sw_valid = 0;
  logic [AW-1:0] fw_addr = 0, fr_addr = 0, sr_addr = 0, sw_addr = 0;
  logic [DW-1:0] fw_data = 0, sw_data = 0;
  logic fr_ready, sr_ready, sw_ready, fr_rvalid, sr_rvalid, bus_conflict;
  logic [DW-1:0] fr_rdata, sr_rdata, mem_wdata;
  logic [DW-1:0] mem_rdata = 0;
  logic mem_cs, mem_we;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] model [256];
  logic [DW-1:0] expv [256];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_cs) begin
      if (mem_we) model[mem_addr] <= mem_wdata;
      else mem_rdata <= model[mem_addr];
    end
  end

  sram_port_arbiter #(.ADDR_W(AW), .DATA_W(DW)) i_sram_port_arbiter (
    .clk(clk), .rst_n(rst_n),
    .fw_valid(fw_valid), .fw_addr(fw_addr), .fw_data(fw_data),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_addr(fr_addr),
    .fr_rvalid(fr_rvalid), .fr_rdata(fr_rdata),
    .sr_valid(sr_valid), .sr_ready(sr_ready), .sr_addr(sr_addr),
    .sr_rvalid(sr_rvalid), .sr_rdata(sr_rdata),
    .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_addr(sw_addr), .sw_data(sw_data),
    .bus_conflict(bus_conflict),
    .mem_cs(mem_cs), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    fw_valid = 0; fr_valid = 0; sr_valid = 0; sw_valid = 0;
  endtask

  // drive at negedge, combinational checks 1 ns later
  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    at_neg();
    chk("R9 fr_rvalid", fr_rvalid, 0);
    chk("R9 sr_rvalid", sr_rvalid, 0);
    chk("R9 readies", {fr_ready, sr_ready, sw_ready}, 0);
    chk("R7 idle cs", mem_cs, 0);
  endtask

  task automatic fw_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    at_neg();
    clr(); fw_valid = 1; fw_addr = a; fw_data = d; #1;
    chk("R2 cs", mem_cs, 1);
    chk("R2 we", mem_we, 1);
    chk("R2 addr", mem_addr, a);
    chk("R2 data", mem_wdata, d);
    expv[a] = d;
    @(negedge clk); clr();
  endtask

  task automatic t_fw_under_load();
    at_neg();
    clr(); fw_valid = 1; fw_addr = 8'h44; fw_data = 32'hCAFE0044;
    fr_valid = 1; fr_addr = 8'h01; sw_valid = 1; sw_addr = 8'h02; sw_data = 32'h1; #1;
    chk("R2 addr under load", mem_addr, 8'h44);
    chk("R1 no ready under fw", {fr_ready, sr_ready, sw_ready}, 0);
    expv[8'h44] = 32'hCAFE0044;
    @(negedge clk); clr();
  endtask

  task automatic t_contention();
    at_neg();
    clr();
    fw_valid = 1; fw_addr = 8'h10; fw_data = 32'hA5A50010;
    fr_valid = 1; fr_addr = 8'h20;
    sr_valid = 1; sr_addr = 8'h30; #1;
    chk("R2 fw first", mem_addr, 8'h10);
    chk("R1 fr stalled", fr_ready, 0);
    chk("R4 sr stalled", sr_ready, 0);
    expv[8'h10] = 32'hA5A50010;
    @(negedge clk); fw_valid = 0; #1;
    chk("R3 fr ready", fr_ready, 1);
    chk("R3 fr addr", mem_addr, 8'h20);
    chk("R8 read we", mem_we, 0);
    chk("R4 sr still stalled", sr_ready, 0);
    @(negedge clk); fr_valid = 0; #1;
    chk("R5 fr rvalid", fr_rvalid, 1);
    chk("R5 fr rdata", fr_rdata, expv[8'h20]);
    chk("R5 sr rvalid low", sr_rvalid, 0);
    chk("R4 sr ready", sr_ready, 1);
    @(negedge clk); sr_valid = 0; #1;
    chk("R5 sr rvalid", sr_rvalid, 1);
    chk("R5 sr rdata", sr_rdata, expv[8'h30]);
    chk("R5 fr rvalid once", fr_rvalid, 0);
    chk("R7 idle", mem_cs, 0);
    @(negedge clk); #1;
    chk("R5 sr rvalid once", sr_rvalid, 0);
  endtask

  task automatic t_sys_write_readback();
    at_neg();
    clr(); sw_valid = 1; sw_addr = 8'h55; sw_data = 32'h0BADF00D; #1;
    chk("R8 sw ready", sw_ready, 1);
    chk("R8 sw we", mem_we, 1);
    chk("R8 sw addr", mem_addr, 8'h55);
    chk("R8 sw data", mem_wdata, 32'h0BADF00D);
    expv[8'h55] = 32'h0BADF00D;
    @(negedge clk); clr(); sr_valid = 1; sr_addr = 8'h55; #1;
    chk("R4 sr alone", sr_ready, 1);
    @(negedge clk); clr(); #1;
    chk("R5 readback", sr_rdata, 32'h0BADF00D);
  endtask

  task automatic t_conflict();
    at_neg();
    clr(); sr_valid = 1; sr_addr = 8'h44; sw_valid = 1; sw_addr = 8'h66; sw_data = 32'h66; #1;
    chk("R6 conflict flag", bus_conflict, 1);
    chk("R6 sw served", sw_ready, 1);
    chk("R6 sr held", sr_ready, 0);
    expv[8'h66] = 32'h66;
    @(negedge clk); sw_valid = 0; #1;
    chk("R6 flag clears", bus_conflict, 0);
    chk("R6 sr next", sr_ready, 1);
    @(negedge clk); clr(); #1;
    chk("R5 sr after conflict", sr_rdata, expv[8'h44]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      model[i] = 0; expv[i] = 0;
    end
    repeat (2) @(posedge clk);
    t_reset();
    rst_n = 1;
    fw_write(8'h20, 32'h11112020);
    fw_write(8'h30, 32'h22223030);
    t_fw_under_load();
    t_contention();
    t_sys_write_readback();
    t_conflict();
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule